// File: doc/BRIEF.md
# Device Idle Timer Bank with SMI Request

This block holds five power-management idle timers: one for keyboard and mouse traffic, three for address windows that software defines, and one for video traffic. Each timer has an enable bit and a 16-bit reload count. Once enabled, a timer counts down by one on each timebase tick. A bus access that falls inside the traffic the timer watches reloads it to its programmed count. If a timer reaches zero with no access in the meantime, the device is taken to be idle, and the block records this in a sticky status bit and raises a system-management interrupt request.

The block watches a bus-access port: a strobe, an address, a flag that tells I/O from memory, and a flag that an upstream decoder sets for accesses in the video range. Software uses a simple register port for programming. Writes complete in one cycle and reads are combinational. Status is kept at two levels. Each timer has its own sticky bit, cleared by writing 1. A summary bit stays set while any per-timer bit is set.

Top module: `idle_smi_bank`

## Requirements
- R1: Register 0 holds the enable bits. Bit 3 enables keyboard/mouse, bits 4, 5 and 6 enable user windows 1, 2 and 3, and bit 7 enables video. A disabled timer never sets its status bit.
- R2: After reset, all enable bits, status bits and the summary bit are 0, and smi_req is low.
- R3: Writing an enable bit from 0 to 1 loads that timer with its count. An access that hits an enabled timer's range reloads the timer with its count.
- R4: An enabled timer with a nonzero value decrements on each cycle with tick high. The edge at which the value goes from 1 to 0 sets the timer's status bit, and smi_req is high from that edge on.
- R5: I/O accesses to 060h and 064h reload the keyboard/mouse timer. A memory access to the same addresses does not.
- R6: The serial-select field is register 1 bits [1:0]. When it is 2'b10, I/O accesses to 3F8h–3FFh also reload the keyboard/mouse timer. When it is 2'b11, I/O accesses to 2F8h–2FFh reload it instead. Any other value adds neither range.
- R7: Each user window n (n = 1..3) has a base address at register 8+n and a control word at register 11+n. In the control word, bit 4 selects I/O (1) or memory (0), and bits [3:0] give how many low address bits are ignored. An access matches when its space agrees with bit 4 and its remaining address bits equal the base.
- R8: Any access with the video flag set reloads the video timer.
- R9: A timer holding zero never expires, whether its count is zero or it has already expired. It stays at zero until it is reloaded.
- R10: Register 2 holds the per-timer status bits, in the same positions as the enable bits. Writing 1 to a bit clears it, and a bit set by an expiry in the same cycle stays set. smi_req is the OR of these bits. Register 3 bit 0 is the summary bit, which is set exactly while any status bit is set.
- R11: If a reload and an expiry would happen in the same cycle, the reload wins and no status bit is set.
- R12: Registers 4 to 8 hold the reload counts for keyboard/mouse, user windows 1 to 3, and video, in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase pulse, one decrement per high cycle |
| acc_valid | input | 1 | Bus access observed this cycle |
| acc_addr | input | 16 | Address of the observed access |
| acc_is_io | input | 1 | 1 for an I/O access, 0 for a memory access |
| acc_video | input | 1 | Access falls in the video address range |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr (combinational) |
| smi_req | output | 1 | System-management interrupt request |

## Verification
The assertions assume three things about the inputs: rst_n is asserted at the start, tick, the access strobe and the write strobe each last whole clock cycles, and every input is stable around the rising edge. The stimulus changes every input on the falling edge only. Random traffic is biased toward the fixed keyboard and serial ports and toward the programmed window bases, and counts are kept small so that expiries, hits on the last count and clears in the same cycle as an expiry happen often.

// File: rtl/idle_smi_pkg.sv
package idle_smi_pkg;
   localparam int unsigned REG_AW     = 4;
   localparam int unsigned ENA_LSB    = 3;
   localparam int unsigned CTRL_W     = 5;
   localparam int unsigned RA_ENABLE  = 0;
   localparam int unsigned RA_SERSEL  = 1;
   localparam int unsigned RA_STATUS  = 2;
   localparam int unsigned RA_SUMMARY = 3;
   localparam int unsigned RA_COUNT0  = 4;
   localparam int unsigned RA_BASE0   = 9;
   localparam int unsigned RA_CTRL0   = 12;
   localparam int unsigned MK_KEYBD   = 0;
   localparam int unsigned MK_USER    = 1;
   localparam int unsigned MK_VIDEO   = 2;
   localparam logic [1:0]  SER_PRIMARY   = 2'b10;
   localparam logic [1:0]  SER_SECONDARY = 2'b11;
endpackage

// File: rtl/idle_addr_match.sv
module idle_addr_match
   import idle_smi_pkg::*;
#(
   parameter int unsigned ADDR_W  = 16,
   parameter int unsigned KIND    = MK_KEYBD,
   parameter logic [15:0] PORT_A  = 16'h0060,
   parameter logic [15:0] PORT_B  = 16'h0064,
   parameter logic [15:0] SER_P   = 16'h03F8,
   parameter logic [15:0] SER_S   = 16'h02F8
) (
   input  logic              acc_valid,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              acc_is_io,
   input  logic              acc_video,
   input  logic [1:0]        ser_sel,
   input  logic [ADDR_W-1:0] win_base,
   input  logic [CTRL_W-1:0] win_ctrl,
   output logic              hit
);
   localparam logic [ADDR_W-1:0] PA = ADDR_W'(PORT_A);
   localparam logic [ADDR_W-1:0] PB = ADDR_W'(PORT_B);
   localparam logic [ADDR_W-1:0] SP = ADDR_W'(SER_P);
   localparam logic [ADDR_W-1:0] SS = ADDR_W'(SER_S);

   if (ADDR_W < 12 || ADDR_W > 32) begin : g_bad_aw
      $error("idle_addr_match: ADDR_W out of range");
   end
   if (KIND > MK_VIDEO) begin : g_bad_kind
      $error("idle_addr_match: unknown KIND");
   end

   if (KIND == MK_KEYBD) begin : g_keybd
      logic fixed_hit, pri_hit, sec_hit;
      logic unused_kb;
      assign fixed_hit = (acc_addr == PA) || (acc_addr == PB);
      assign pri_hit   = (ser_sel == SER_PRIMARY)   && (acc_addr[ADDR_W-1:3] == SP[ADDR_W-1:3]);
      assign sec_hit   = (ser_sel == SER_SECONDARY) && (acc_addr[ADDR_W-1:3] == SS[ADDR_W-1:3]);
      assign hit       = acc_valid && acc_is_io && (fixed_hit || pri_hit || sec_hit);
      assign unused_kb = ^{win_base, win_ctrl, acc_video};
   end else if (KIND == MK_USER) begin : g_user
      logic [ADDR_W-1:0] keep_mask;
      logic              space_ok;
      logic              unused_us;
      assign keep_mask = {ADDR_W{1'b1}} << win_ctrl[3:0];
      assign space_ok  = (acc_is_io == win_ctrl[4]);
      assign hit       = acc_valid && space_ok && (((acc_addr ^ win_base) & keep_mask) == '0);
      assign unused_us = ^{ser_sel, acc_video};
   end else begin : g_video
      logic unused_vd;
      assign hit       = acc_valid && acc_video;
      assign unused_vd = ^{acc_addr, acc_is_io, ser_sel, win_base, win_ctrl};
   end
endmodule

// File: rtl/idle_down_timer.sv
module idle_down_timer #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             en_rise,
   input  logic             hit,
   input  logic             tick,
   input  logic [CNT_W-1:0] reload,
   output logic             expire
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cw
      $error("idle_down_timer: CNT_W out of range");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             load;
   logic             dec;

   assign load   = en_rise || (en && hit);
   assign dec    = en && tick && (cnt_q != '0);
   assign expire = dec && !load && (cnt_q == ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt_q <= '0;
      else if (load) cnt_q <= reload;
      else if (dec)  cnt_q <= cnt_q - ONE;
   end

   AST_LOAD_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (en && hit) |=> (cnt_q == $past(reload))); // R3
   AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!en) |-> (!expire)); // R1
   AST_HIT_BEATS_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
      (hit) |-> (!expire)); // R11
   AST_ZERO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      ((cnt_q == '0) && !en_rise && !(en && hit)) |=> (cnt_q == '0)); // R9
endmodule

// File: rtl/idle_smi_status.sv
module idle_smi_status #(
   parameter int unsigned N = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] sts,
   output logic         summary,
   output logic         smi
);
   if (N < 1) begin : g_bad_n
      $error("idle_smi_status: N must be positive");
   end

   logic [N-1:0] sts_q, sts_n;
   logic         summary_q;

   assign sts_n = (sts_q & ~clr) | set;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sts_q     <= '0;
         summary_q <= 1'b0;
      end else begin
         sts_q     <= sts_n;
         summary_q <= |sts_n;
      end
   end

   assign sts     = sts_q;
   assign summary = summary_q;
   assign smi     = |sts_q;

   AST_STICKY_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_q != '0) |=> ((($past(sts_q) & ~$past(clr)) & ~sts_q) == '0)); // R10
   AST_SET_RAISES_SMI: assert property (@(posedge clk) disable iff (!rst_n)
      (set != '0) |=> smi); // R4
   AST_SUMMARY_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
      summary == smi); // R10
endmodule

// File: rtl/idle_smi_bank.sv
module idle_smi_bank
   import idle_smi_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned N_USER = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              acc_valid,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              acc_is_io,
   input  logic              acc_video,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              smi_req
);
   localparam int unsigned N_TMR = N_USER + 2;
   localparam int unsigned VID_I = N_TMR - 1;

   if (N_USER < 1 || N_USER > 3) begin : g_bad_user
      $error("idle_smi_bank: N_USER must be 1..3");
   end
   if (ENA_LSB + N_TMR > 8 || ENA_LSB + N_TMR > DATA_W) begin : g_bad_bits
      $error("idle_smi_bank: enable field does not fit");
   end
   if (ADDR_W > DATA_W || CNT_W > DATA_W) begin : g_bad_dw
      $error("idle_smi_bank: DATA_W too narrow");
   end

   logic [N_TMR-1:0]  en_q;
   logic [1:0]        sel_q;
   logic [CNT_W-1:0]  reload_q [N_TMR];
   logic [ADDR_W-1:0] base_q   [N_USER];
   logic [CTRL_W-1:0] ctrl_q   [N_USER];

   logic              wr_enable, wr_status;
   logic [N_TMR-1:0]  en_rise, hit_v, expire_v, clr_v, sts_v;
   logic              summary;
   logic              unused_wd;

   assign wr_enable = reg_we && (reg_addr == REG_AW'(RA_ENABLE));
   assign wr_status = reg_we && (reg_addr == REG_AW'(RA_STATUS));
   assign en_rise   = wr_enable ? (reg_wdata[ENA_LSB +: N_TMR] & ~en_q) : '0;
   assign clr_v     = wr_status ? reg_wdata[ENA_LSB +: N_TMR] : '0;
   assign unused_wd = ^reg_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= '0;
         sel_q <= '0;
         for (int i = 0; i < N_TMR; i++) reload_q[i] <= '0;
         for (int j = 0; j < N_USER; j++) begin
            base_q[j] <= '0;
            ctrl_q[j] <= '0;
         end
      end else if (reg_we) begin
         if (reg_addr == REG_AW'(RA_ENABLE)) en_q  <= reg_wdata[ENA_LSB +: N_TMR];
         if (reg_addr == REG_AW'(RA_SERSEL)) sel_q <= reg_wdata[1:0];
         for (int i = 0; i < N_TMR; i++)
            if (reg_addr == REG_AW'(RA_COUNT0 + i)) reload_q[i] <= reg_wdata[CNT_W-1:0];
         for (int j = 0; j < N_USER; j++) begin
            if (reg_addr == REG_AW'(RA_BASE0 + j)) base_q[j] <= reg_wdata[ADDR_W-1:0];
            if (reg_addr == REG_AW'(RA_CTRL0 + j)) ctrl_q[j] <= reg_wdata[CTRL_W-1:0];
         end
      end
   end

   for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
      localparam int unsigned KIND = (i == 0) ? MK_KEYBD : ((i == VID_I) ? MK_VIDEO : MK_USER);
      localparam int unsigned UIDX = (KIND == MK_USER) ? (i - 1) : 0;

      idle_addr_match #(.ADDR_W(ADDR_W), .KIND(KIND)) u_match (
         .acc_valid (acc_valid),
         .acc_addr  (acc_addr),
         .acc_is_io (acc_is_io),
         .acc_video (acc_video),
         .ser_sel   (sel_q),
         .win_base  (base_q[UIDX]),
         .win_ctrl  (ctrl_q[UIDX]),
         .hit       (hit_v[i])
      );

      idle_down_timer #(.CNT_W(CNT_W)) u_timer (
         .clk     (clk),
         .rst_n   (rst_n),
         .en      (en_q[i]),
         .en_rise (en_rise[i]),
         .hit     (hit_v[i]),
         .tick    (tick),
         .reload  (reload_q[i]),
         .expire  (expire_v[i])
      );
   end

   idle_smi_status #(.N(N_TMR)) u_status (
      .clk     (clk),
      .rst_n   (rst_n),
      .set     (expire_v),
      .clr     (clr_v),
      .sts     (sts_v),
      .summary (summary),
      .smi     (smi_req)
   );

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == REG_AW'(RA_ENABLE))  reg_rdata[ENA_LSB +: N_TMR] = en_q;
      if (reg_addr == REG_AW'(RA_SERSEL))  reg_rdata[1:0] = sel_q;
      if (reg_addr == REG_AW'(RA_STATUS))  reg_rdata[ENA_LSB +: N_TMR] = sts_v;
      if (reg_addr == REG_AW'(RA_SUMMARY)) reg_rdata[0] = summary;
      for (int i = 0; i < N_TMR; i++)
         if (reg_addr == REG_AW'(RA_COUNT0 + i)) reg_rdata[CNT_W-1:0] = reload_q[i];
      for (int j = 0; j < N_USER; j++) begin
         if (reg_addr == REG_AW'(RA_BASE0 + j)) reg_rdata[ADDR_W-1:0] = base_q[j];
         if (reg_addr == REG_AW'(RA_CTRL0 + j)) reg_rdata[CTRL_W-1:0] = ctrl_q[j];
      end
   end

   AST_DISABLED_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
      ((sts_v & ~en_q) == '0) |=> (((sts_v & ~$past(sts_v)) & ~$past(en_q)) == '0)); // R1
   AST_VIDEO_HIT_SPARES: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_video) |-> !expire_v[VID_I]); // R8
endmodule

// File: tb/sim_idle_smi_bank.sv
module sim_idle_smi_bank;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0, acc_valid = 1'b0, acc_is_io = 1'b0, acc_video = 1'b0;
   logic [15:0] acc_addr = '0;
   logic        reg_we = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        smi_req;

   int n_tests = 0, n_fail = 0;
   bit done = 0;
   string cur_req = "R2";

   logic [4:0]  m_en = '0, m_sts = '0;
   logic [1:0]  m_sel = '0;
   logic [15:0] m_rel [5];
   logic [15:0] m_cnt [5];
   logic [15:0] m_base [3];
   logic [4:0]  m_ctrl [3];
   logic [4:0]  en_shadow = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   idle_smi_bank u0 (
      .clk(clk), .rst_n(rst_n), .tick(tick), .acc_valid(acc_valid), .acc_addr(acc_addr),
      .acc_is_io(acc_is_io), .acc_video(acc_video), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .smi_req(smi_req)
   );

   task automatic check(string req, string what, logic [15:0] got, logic [15:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
      end
   endtask

   function automatic logic f_hit(int i, logic [15:0] a, logic io, logic vid);
      logic [15:0] km;
      if (i == 0)
         return io && (a == 16'h0060 || a == 16'h0064 ||
                (m_sel == 2'b10 && a[15:3] == 13'h007F) ||
                (m_sel == 2'b11 && a[15:3] == 13'h005F));
      if (i == 4) return vid;
      km = 16'hFFFF << m_ctrl[i-1][3:0];
      return (io == m_ctrl[i-1][4]) && (((a ^ m_base[i-1]) & km) == 16'h0);
   endfunction

   task automatic model(logic we, logic [3:0] a, logic [15:0] d, logic tk,
                        logic av, logic [15:0] ad, logic io, logic vid);
      for (int i = 0; i < 5; i++) begin
         logic h, rise, ex, clr;
         h    = av && f_hit(i, ad, io, vid);
         rise = we && a == 4'd0 && d[3+i] && !m_en[i];
         ex   = m_en[i] && tk && m_cnt[i] == 16'd1 && !h && !rise;
         clr  = we && a == 4'd2 && d[3+i];
         if (rise || (m_en[i] && h)) m_cnt[i] = m_rel[i];
         else if (m_en[i] && tk && m_cnt[i] != 16'd0) m_cnt[i] = m_cnt[i] - 16'd1;
         m_sts[i] = (m_sts[i] && !clr) || ex;
      end
      if (we) begin
         if (a == 4'd0) m_en = d[7:3];
         if (a == 4'd1) m_sel = d[1:0];
         if (a >= 4'd4 && a <= 4'd8) m_rel[a-4] = d;
         if (a >= 4'd9 && a <= 4'd11) m_base[a-9] = d;
         if (a >= 4'd12 && a <= 4'd14) m_ctrl[a-12] = d[4:0];
      end
   endtask

   task automatic step(logic we, logic [3:0] a, logic [15:0] d, logic tk,
                       logic av, logic [15:0] ad, logic io, logic vid);
      @(negedge clk);
      reg_we = we; reg_addr = a; reg_wdata = d; tick = tk;
      acc_valid = av; acc_addr = ad; acc_is_io = io; acc_video = vid;
      model(we, a, d, tk, av, ad, io, vid);
      @(posedge clk); #1;
      reg_we = 1'b0; reg_addr = 4'd2; #1;
      check(cur_req, "status reg", reg_rdata, {8'h0, m_sts, 3'b000});
      reg_addr = 4'd3; #1;
      check(cur_req, "summary bit", reg_rdata, {15'h0, |m_sts});
      check(cur_req, "smi_req", {15'h0, smi_req}, {15'h0, |m_sts});
   endtask

   task automatic wr(logic [3:0] a, logic [15:0] d);
      step(1'b1, a, d, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0);
   endtask
   task automatic tk(int n);
      for (int k = 0; k < n; k++) step(1'b0, 4'd0, 16'h0, 1'b1, 1'b0, 16'h0, 1'b0, 1'b0);
   endtask
   task automatic acc(logic [15:0] ad, logic io, logic vid, logic t);
      step(1'b0, 4'd0, 16'h0, t, 1'b1, ad, io, vid);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2024));
      for (int i = 0; i < 5; i++) begin m_rel[i] = '0; m_cnt[i] = '0; end
      for (int j = 0; j < 3; j++) begin m_base[j] = '0; m_ctrl[j] = '0; end
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      // R2: reset state
      reg_addr = 4'd0; #1; check("R2", "enable after reset", reg_rdata, 16'h0);
      reg_addr = 4'd2; #1; check("R2", "status after reset", reg_rdata, 16'h0);
      check("R2", "smi after reset", {15'h0, smi_req}, 16'h0);

      // R12 / R1: count programmed but disabled
      cur_req = "R1";
      wr(4'd4, 16'd3);
      reg_addr = 4'd4; #1; check("R12", "keyboard count readback", reg_rdata, 16'd3);
      tk(5);
      check("R1", "disabled timer quiet", {15'h0, smi_req}, 16'h0);
      // R3 / R4: enable loads, three ticks expire
      cur_req = "R4";
      wr(4'd0, 16'h0008);
      tk(2);
      check("R4", "no smi after 2 ticks", {15'h0, smi_req}, 16'h0);
      tk(1);
      check("R4", "smi after 3rd tick", {15'h0, smi_req}, 16'h1);
      reg_addr = 4'd2; #1; check("R4", "keyboard status bit 3", reg_rdata, 16'h0008);
      // R9: expired timer stays quiet; R10 clear
      cur_req = "R10";
      wr(4'd2, 16'h0008);
      check("R10", "smi cleared by W1C", {15'h0, smi_req}, 16'h0);
      cur_req = "R9";
      tk(4);
      check("R9", "expired timer does not re-expire", {15'h0, smi_req}, 16'h0);
      // R5: fixed ports reload, memory space does not
      cur_req = "R5";
      acc(16'h0060, 1'b1, 1'b0, 1'b0);
      tk(2);
      acc(16'h0064, 1'b1, 1'b0, 1'b0);
      tk(2);
      check("R5", "I/O 064h reloaded", {15'h0, smi_req}, 16'h0);
      acc(16'h0060, 1'b0, 1'b0, 1'b0);
      tk(1);
      check("R5", "memory 060h ignored", {15'h0, smi_req}, 16'h1);
      wr(4'd2, 16'h00F8);
      // R6: serial ranges
      cur_req = "R6";
      wr(4'd1, 16'h0002);
      acc(16'h0060, 1'b1, 1'b0, 1'b0);
      tk(2);
      acc(16'h03FA, 1'b1, 1'b0, 1'b0);
      tk(2);
      check("R6", "3F8h range reloads with select 10", {15'h0, smi_req}, 16'h0);
      wr(4'd1, 16'h0003);
      acc(16'h03FA, 1'b1, 1'b0, 1'b0);
      tk(1);
      check("R6", "3F8h ignored with select 11", {15'h0, smi_req}, 16'h1);
      wr(4'd2, 16'h00F8);
      acc(16'h0060, 1'b1, 1'b0, 1'b0);
      tk(2);
      acc(16'h02FF, 1'b1, 1'b0, 1'b0);
      tk(2);
      check("R6", "2F8h range reloads with select 11", {15'h0, smi_req}, 16'h0);
      wr(4'd0, 16'h0000);
      // R9: zero count never expires (user window 1)
      cur_req = "R9";
      wr(4'd5, 16'd0);
      wr(4'd0, 16'h0010);
      tk(4);
      check("R9", "zero count quiet", {15'h0, smi_req}, 16'h0);
      // R7: user window 2, I/O, 8-byte window at 0300h
      cur_req = "R7";
      wr(4'd10, 16'h0300);
      wr(4'd13, 16'h0013);
      wr(4'd6, 16'd2);
      wr(4'd0, 16'h0020);
      tk(1);
      acc(16'h0305, 1'b1, 1'b0, 1'b0);
      tk(1);
      check("R7", "window hit reloaded", {15'h0, smi_req}, 16'h0);
      acc(16'h0308, 1'b1, 1'b0, 1'b0);
      tk(1);
      check("R7", "outside window ignored", {15'h0, smi_req}, 16'h1);
      wr(4'd2, 16'h00F8);
      // R8 / R11: video timer, reload and expiry in one cycle
      cur_req = "R11";
      wr(4'd8, 16'd2);
      wr(4'd0, 16'h0080);
      tk(1);
      acc(16'h1234, 1'b0, 1'b1, 1'b1);
      check("R11", "reload beats expiry", {15'h0, smi_req}, 16'h0);
      cur_req = "R8";
      tk(1);
      acc(16'h0000, 1'b1, 1'b1, 1'b0);
      tk(1);
      check("R8", "video flag reloads", {15'h0, smi_req}, 16'h0);
      tk(1);
      check("R8", "video expiry", {15'h0, smi_req}, 16'h1);
      reg_addr = 4'd2; #1; check("R8", "video status bit 7", reg_rdata, 16'h0080);
      wr(4'd2, 16'h00F8);

      // Random phase, model compared every cycle
      cur_req = "R3";
      wr(4'd9, 16'h0040);
      wr(4'd11, 16'h0800);
      for (int n = 0; n < 4000; n++) begin
         logic        we, t, av, io, vid;
         logic [3:0]  a;
         logic [15:0] d, ad;
         we  = ($urandom % 12) == 0;
         t   = $urandom % 2;
         av  = ($urandom % 3) == 0;
         io  = ($urandom % 4) != 0;
         vid = ($urandom % 5) == 0;
         case ($urandom % 7)
            0: ad = 16'h0060;
            1: ad = 16'h0064;
            2: ad = 16'h03F8 + 16'($urandom % 8);
            3: ad = 16'h02F8 + 16'($urandom % 8);
            4: ad = 16'h0040 + 16'($urandom % 32);
            5: ad = 16'h0300 + 16'($urandom % 16);
            default: ad = 16'h0800 + 16'($urandom % 4);
         endcase
         case ($urandom % 6)
            0: begin a = 4'd0; d = {8'h0, 5'($urandom), 3'b000}; end
            1: begin a = 4'd1; d = 16'($urandom % 4); end
            2: begin a = 4'd2; d = {8'h0, 5'($urandom), 3'b000}; end
            3: begin a = 4'(4 + $urandom % 5); d = 16'($urandom % 7); end
            4: begin a = 4'(12 + $urandom % 3); d = {11'h0, 1'($urandom), 4'($urandom % 5)}; end
            default: begin a = 4'(9 + $urandom % 3); d = (($urandom % 2) == 0) ? 16'h0040 : 16'h0300; end
         endcase
         cur_req = (n % 2 == 0) ? "R3" : "R10";
         step(we, a, d, t, av, ad, io, vid);
      end

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule